// File: doc/BRIEF.md
# Float immediate constant builder

This unit places floating-point constants into a 64-bit floating-point register without reading memory. It supports two operations. The first is a load. A 16-bit immediate becomes the upper half of a single-precision pattern, which is the same as reading the immediate as a brain-float, and the result is written back widened to double precision. The second is an insert. It reads the register's current double value and narrows it to single precision. It then overwrites the low 16 bits of that single with a new immediate and widens the result again.

A load followed by an insert therefore builds any exact single-precision constant in two steps, stored in double format. Neither operation produces floating-point status. The register file, instruction decode and exception handling sit outside the unit. The unit accepts one operation per cycle and delivers the write one cycle later.

Top module: `fp_const_builder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `wr_en` and `done` are 0 and `wr_data` is all zeros.
- R2: The 16-bit immediate is {`imm_d0`, `imm_d1`, `imm_d2`}. `imm_d0` supplies bits 15..6, `imm_d1` bits 5..1 and `imm_d2` bit 0. For example, 0x3FFF loads 0x3FFF_E000_0000_0000 (+1.9921875).
- R3: A load (`op_insert`=0) writes the double value of the single {imm, 16'h0000}. Examples: 0x3F80 gives 0x3FF0_0000_0000_0000, 0x8000 gives 0x8000_0000_0000_0000, 0xBFC0 gives 0xBFF8_0000_0000_0000 and 0x0000 gives all zeros. The low 29 result bits are always zero.
- R4: An all-ones single exponent widens to an all-ones double exponent, with the mantissa carried over. Examples: 0x7F80 gives 0x7FF0_0000_0000_0000, 0xFF80 gives 0xFFF0_0000_0000_0000 and 0x7FC0 gives 0x7FF8_0000_0000_0000.
- R5: A subnormal single is normalised during widening. Example: immediate 0x0040 gives 0x3800_0000_0000_0000.
- R6: An insert (`op_insert`=1) narrows `rd_data` to single precision by taking exponent and mantissa bits directly, then replaces single bits 15..0 with the immediate and widens the result. Example: `rd_data` 0x3FF0_0000_0000_0000 with immediate 0x8000 gives 0x3FF0_1000_0000_0000.
- R7: An insert narrows a double that holds a widened subnormal single back to that subnormal pattern before patching it.
- R8: Each cycle with `in_valid`=1 produces `wr_en`=1 and `done`=1 in the next cycle only. With no valid input, both stay 0 and `wr_data` holds its last value.
- R9: A load ignores `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_insert | input | 1 | 0 = load upper half, 1 = insert low half |
| imm_d0 | input | 10 | Immediate bits 15..6 |
| imm_d1 | input | 5 | Immediate bits 5..1 |
| imm_d2 | input | 1 | Immediate bit 0 |
| rd_data | input | 64 | Current register value (double format) |
| wr_data | output | 64 | Value to write to the register |
| wr_en | output | 1 | Register write enable |
| done | output | 1 | Completion pulse, coincident with the write |

## Verification
The assertions on an insert assume that `rd_data` holds a double that is exactly a widened single. Such a value has zero low 29 mantissa bits and an exponent that is special or within single range. Under that assumption the narrowing loses nothing, and the sign carries through unchanged. The stimulus keeps to this by feeding each insert the value that the bench's own register model holds after an earlier load or insert. Loads, which the assumption does not cover, are also driven with arbitrary `rd_data`.

// File: rtl/fp_const_builder.sv
module fp_const_builder #(
  parameter int DW = 64,
  parameter int SW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          op_insert,
  input  logic [9:0]    imm_d0,
  input  logic [4:0]    imm_d1,
  input  logic          imm_d2,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] wr_data,
  output logic          wr_en,
  output logic          done
);
  localparam int PAD = SW - IW;

  logic [IW-1:0] imm;
  logic [SW-1:0] narrowed;
  logic [SW-1:0] single_v;
  logic [DW-1:0] widened;

  assign imm = {imm_d0, imm_d1, imm_d2};

  function automatic logic [63:0] widen(input logic [31:0] s);
    logic [22:0] f;
    logic [4:0]  lz;
    logic [22:0] nf;
    logic [10:0] ne;
    f  = s[22:0];
    lz = 5'd22;
    for (int i = 0; i <= 22; i++)
      if (f[i]) lz = 5'(22 - i);
    nf = f << (lz + 5'd1);
    ne = 11'd896 - {6'd0, lz};
    if (s[30:23] == 8'hFF)
      widen = {s[31], 11'h7FF, f, 29'd0};
    else if (s[30:23] == 8'h00 && f == 23'd0)
      widen = {s[31], 63'd0};
    else if (s[30:23] == 8'h00)
      widen = {s[31], ne, nf, 29'd0};
    else
      widen = {s[31], {3'd0, s[30:23]} + 11'd896, f, 29'd0};
  endfunction

  function automatic logic [31:0] narrow(input logic [63:0] d);
    logic [10:0] e;
    logic [10:0] sh;
    logic [23:0] m;
    e  = d[62:52];
    sh = 11'd897 - e;
    m  = {1'b1, d[51:29]} >> sh;
    if (e == 11'h7FF || e == 11'd0 || e >= 11'd897)
      narrow = {d[63], e[10], e[6:0], d[51:29]};
    else if (e >= 11'd874)
      narrow = {d[63], 8'h00, m[22:0]};
    else
      narrow = {d[63], 31'd0};
  endfunction

  assign narrowed = narrow(rd_data);
  assign single_v = op_insert ? {narrowed[SW-1:IW], imm} : {imm, {PAD{1'b0}}};
  assign widened  = widen(single_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_data <= '0;
      wr_en   <= 1'b0;
      done    <= 1'b0;
    end else begin
      wr_en <= in_valid;
      done  <= in_valid;
      if (in_valid) wr_data <= widened;
    end
  end
endmodule

module fp_const_builder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        op_insert,
  input logic [9:0]  imm_d0,
  input logic [63:0] rd_data,
  input logic [63:0] wr_data,
  input logic        wr_en,
  input logic        done
);
  a_r8_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (wr_en && done));
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && !done));
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(wr_data));
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (wr_data[28:0] == 29'd0));
  a_r3_sign_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_insert) |=> (wr_data[63] == $past(imm_d0[9])));
  a_r4_special_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_insert && imm_d0[8:1] == 8'hFF) |=> (wr_data[62:52] == 11'h7FF));
  a_r6_sign_insert: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_insert) |=> (wr_data[63] == $past(rd_data[63])));
endmodule

bind fp_const_builder fp_const_builder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_insert(op_insert),
  .imm_d0(imm_d0), .rd_data(rd_data), .wr_data(wr_data), .wr_en(wr_en), .done(done)
);

// File: tb/fp_const_builder_tb.sv
module fp_const_builder_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        op_insert = 0;
  logic [9:0]  imm_d0 = 0;
  logic [4:0]  imm_d1 = 0;
  logic        imm_d2 = 0;
  logic [63:0] rd_data = 0;
  logic [63:0] wr_data;
  logic        wr_en, done;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic        exp_en = 0;
  logic [63:0] exp_data = 0;
  string       prev_tag = "R1 reset";
  logic [63:0] model_reg = 0;

  fp_const_builder u_dut (.*);

  always #10 clk = ~clk;

  function automatic logic [63:0] m_widen(logic [31:0] s);
    int e = s[30:23];
    logic [23:0] m = {1'b0, s[22:0]};
    int ed;
    if (e == 255) return {s[31], 11'h7FF, s[22:0], 29'd0};
    if (e == 0 && m == 0) return {s[31], 63'd0};
    if (e == 0) begin
      ed = 897;
      while (m[23] == 1'b0) begin m = m << 1; ed = ed - 1; end
    end else begin
      ed = e - 127 + 1023;
    end
    return {s[31], 11'(ed), m[22:0], 29'd0};
  endfunction

  function automatic logic [31:0] m_narrow(logic [63:0] d);
    int e = d[62:52];
    logic [23:0] m = {1'b1, d[51:29]};
    if (e == 2047) return {d[63], 8'hFF, d[51:29]};
    if (e == 0) return {d[63], 31'd0};
    if (e >= 897) return {d[63], 8'(e - 896), d[51:29]};
    for (int k = 0; k < 897 - e; k++) m = m >> 1;
    return {d[63], 8'h00, m[22:0]};
  endfunction

  task automatic compare();
    n_cmp++;
    if (wr_en !== exp_en || done !== exp_en || wr_data !== exp_data) begin
      n_bad++;
      $display("FAIL %s: got en=%b done=%b data=%h, expected en=%b data=%h",
               prev_tag, wr_en, done, wr_data, exp_en, exp_data);
    end
  endtask

  task automatic step(bit v, bit op, logic [15:0] imm, logic [63:0] rd,
                      bit use_lit, logic [63:0] lit, string tag);
    logic [63:0] r;
    @(negedge clk);
    compare();
    in_valid = v; op_insert = op;
    imm_d0 = imm[15:6]; imm_d1 = imm[5:1]; imm_d2 = imm[0];
    rd_data = rd;
    exp_en = v;
    prev_tag = tag;
    if (v) begin
      if (op) r = m_widen({m_narrow(rd)[31:16], imm});
      else    r = m_widen({imm, 16'h0000});
      if (use_lit) begin
        n_cmp++;
        if (r !== lit) begin
          n_bad++;
          $display("FAIL %s: model got %h, expected %h", tag, r, lit);
        end
        r = lit;
      end
      exp_data = r;
      model_reg = r;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, "R1 after reset");
    step(1, 0, 16'h3F80, 0, 1, 64'h3FF0_0000_0000_0000, "R3 +1.0");
    step(1, 0, 16'h8000, 0, 1, 64'h8000_0000_0000_0000, "R3 -0.0");
    step(1, 0, 16'hBFC0, 0, 1, 64'hBFF8_0000_0000_0000, "R3 -1.5");
    step(1, 0, 16'h0000, 0, 1, 64'h0, "R3 +0.0");
    step(1, 0, 16'h3FFF, 0, 1, 64'h3FFF_E000_0000_0000, "R2 field order");
    step(1, 0, 16'h7F80, 0, 1, 64'h7FF0_0000_0000_0000, "R4 +inf");
    step(1, 0, 16'hFF80, 0, 1, 64'hFFF0_0000_0000_0000, "R4 -inf");
    step(1, 0, 16'h7FC0, 0, 1, 64'h7FF8_0000_0000_0000, "R4 qNaN");
    step(1, 0, 16'h0040, 0, 1, 64'h3800_0000_0000_0000, "R5 subnormal");
    step(1, 0, 16'h0001, 0, 0, 0, "R5 smallest subnormal");
    step(1, 1, 16'h1234, model_reg, 0, 0, "R7 insert on subnormal");
    step(1, 0, 16'h3F80, 64'hDEAD_BEEF_0123_4567, 1, 64'h3FF0_0000_0000_0000, "R9 rd ignored");
    step(1, 1, 16'h8000, model_reg, 1, 64'h3FF0_1000_0000_0000, "R6 insert example");
    step(0, 1, 16'hFFFF, 64'h1, 0, 0, "R8 idle hold");
    step(0, 0, 0, 0, 0, 0, "R8 idle hold 2");
    step(1, 0, 16'h7FC0, 0, 0, 0, "R4 NaN load");
    step(1, 1, 16'h0001, model_reg, 0, 0, "R6 insert on NaN");
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(1, 0, lf, {lf, lf, lf, lf}, 0, 0, "R3 random load");
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(1, 1, lf, model_reg, 0, 0, "R6 random insert");
      if (lf[0]) step(0, 0, 0, 0, 0, 0, "R8 random gap");
    end
    step(0, 0, 0, 0, 0, 0, "R8 final");
    @(negedge clk);
    compare();
    summary();
  end
endmodule